// File: doc/BRIEF.md
# Streaming Haar Baseline-Drift Canceller

This block cleans a stream of 10-bit unsigned biosignal samples by removing slow baseline wander. Incoming samples land in one of two sample banks. When a bank holds a full block it is handed over to processing, and the other bank starts to fill. Processing reads the handed-over bank out one sample per cycle. Each sample goes through a cascade of undecimated Haar lowpass levels. At level j the two non-zero taps sit 2^j samples apart, so every level reduces to a single add against a delay line of 2^j entries.

The deepest approximation, scaled back to sample units, is taken as the drift estimate. It is subtracted from a copy of the sample that has been delayed to line up with the cascade's group delay. The result is a signed, saturated sample sent out on a valid/data port. The delay lines run continuously across block boundaries and are cleared only by reset. A block that completes while the previous block is still being read out is discarded and flagged.

Top module: `drift_canceller`

## Requirements
- R1: A sample is written into the filling bank on every cycle in which `in_valid` is high. When the BLOCK-th sample of a block is written while no block is being read, the block is handed to processing and the other bank becomes the filling bank. Processing reads the block's samples in arrival order, one per cycle.
- R2: For each processed sample n, the drift estimate equals floor(S / 2^LEVELS), where S is the sum of processed samples n-2^LEVELS+1 through n.
- R3: Each output value equals processed sample n-D minus the drift estimate for sample n, where D = 2^(LEVELS-1)-1. The value is presented on `out_data` as two's complement, OUT_W bits wide.
- R4: A difference above 2^(OUT_W-1)-1 is output as 2^(OUT_W-1)-1. A difference below -2^(OUT_W-1) is output as -2^(OUT_W-1).
- R5: Processed samples that would lie before the first sample processed since reset count as zero, both in the drift sum and in the delayed copy.
- R6: `out_valid` stays low for the first D samples processed after reset. After that it is high once for each processed sample, so N processed samples give N-D outputs.
- R7: A block may complete while the reader is still busy, including the cycle of the reader's last read. In that case `overrun` is high for exactly one cycle, the completed block is never processed, and the following samples refill the same bank.
- R8: While `rst_n` is low, `out_valid` and `overrun` are low. Reset clears every history, so processing after reset starts again from zeros.
- R9: History carries over between consecutive processed blocks. The first outputs of a block use the tail samples of the block before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_data | input | SAMPLE_W | Unsigned sample code |
| out_valid | output | 1 | Cleaned sample strobe |
| out_data | output | OUT_W | Cleaned sample, two's complement |
| overrun | output | 1 | One-cycle pulse: completed block discarded |

## Verification
The bench drives step edges in both directions so that the difference crosses both saturation limits. A design that wraps instead of clamping would return values of the wrong sign. Its reference model counts zeros for history before reset, and it tests a second reset after non-zero traffic. A design that leaves stale history in its delay lines would miss on the first outputs after that reset, and a design that re-zeroes at each block boundary would miss on every block after the first. The overrun case writes two blocks back to back at full rate, followed by a slower third block. A design that lets the second block through, or that corrupts the block being read, would produce the wrong output stream, the wrong number of outputs, or the wrong number of overrun pulses.

// File: rtl/drift_pkg.sv
package drift_pkg;

    // integer part of the Haar cascade group delay
    function automatic int delay_for(input int levels);
        return (1 << (levels - 1)) - 1;
    endfunction

    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/sample_delay.sv
module sample_delay #(
    parameter int W     = 10,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] line_q [DEPTH];
    logic [W-1:0] line_d [DEPTH];

    always_comb begin
        line_d = line_q;
        if (en) begin
            line_d[0] = din;
            for (int i = 1; i < DEPTH; i++) begin
                line_d[i] = line_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '{default: '0};
        else        line_q <= line_d;
    end

    assign dout = line_q[DEPTH-1];
endmodule

// File: rtl/haar_stage.sv
module haar_stage #(
    parameter int W    = 16,
    parameter int SPAN = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    logic [W-1:0] tail;

    sample_delay #(.W(W), .DEPTH(SPAN)) u_line (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .din  (x),
        .dout (tail)
    );

    // dilated Haar lowpass, kept unscaled: the two taps are SPAN apart
    assign y = x + tail;

    // R2: accumulator width leaves room, the sum never wraps
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (y >= x));
endmodule

// File: rtl/pingpong_buffer.sv
module pingpong_buffer #(
    parameter int W     = 10,
    parameter int BLOCK = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         s_vld,
    output logic [W-1:0] s_dat,
    output logic         overrun
);
    localparam int IDX_W = (BLOCK > 1) ? $clog2(BLOCK) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BLOCK - 1);

    typedef struct packed {
        logic             wr_bank;
        logic [IDX_W-1:0] wr_idx;
        logic             rd_busy;
        logic             rd_bank;
        logic [IDX_W-1:0] rd_idx;
        logic             vld;
        logic             ovr;
    } pp_t;

    pp_t          q, d;
    logic [W-1:0] mem [2*BLOCK];
    logic [W-1:0] dat_q;

    always_comb begin
        d     = q;
        d.vld = q.rd_busy;
        d.ovr = 1'b0;
        if (q.rd_busy) begin
            d.rd_idx = q.rd_idx + 1'b1;
            if (q.rd_idx == LAST) begin
                d.rd_busy = 1'b0;
                d.rd_idx  = '0;
            end
        end
        if (in_valid) begin
            d.wr_idx = q.wr_idx + 1'b1;
            if (q.wr_idx == LAST) begin
                d.wr_idx = '0;
                if (q.rd_busy) begin
                    d.ovr = 1'b1;
                end else begin
                    d.rd_busy = 1'b1;
                    d.rd_bank = q.wr_bank;
                    d.rd_idx  = '0;
                    d.wr_bank = ~q.wr_bank;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (in_valid) mem[{q.wr_bank, q.wr_idx}] <= in_data;
        dat_q <= mem[{q.rd_bank, q.rd_idx}];
    end

    assign s_vld   = q.vld;
    assign s_dat   = dat_q;
    assign overrun = q.ovr;

    // R1: the bank under read is never the bank being filled
    a_r1_banks_apart: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd_busy |-> (q.rd_bank != q.wr_bank));
    // R7: an overrun only follows a cycle with the reader busy
    a_r7_overrun_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovr |-> $past(q.rd_busy));
    // R7: the flag is a single-cycle pulse
    a_r7_overrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovr |=> !q.ovr);
endmodule

// File: rtl/drift_canceller.sv
module drift_canceller
    import drift_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int LEVELS   = 6,
    parameter int BLOCK    = 256,
    parameter int OUT_W    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                out_valid,
    output logic [OUT_W-1:0]    out_data,
    output logic                overrun
);
    localparam int ACC_W  = SAMPLE_W + LEVELS;
    localparam int DELAY  = delay_for(LEVELS);
    localparam int CNT_W  = $clog2(DELAY + 1);
    localparam int SAT_HI = (1 << (OUT_W - 1)) - 1;
    localparam int SAT_LO = -(1 << (OUT_W - 1));

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovalid;
        logic [OUT_W-1:0] odata;
    } out_t;

    logic                       s_vld;
    logic [SAMPLE_W-1:0]        s_dat;
    logic [SAMPLE_W-1:0]        dly_x;
    logic [SAMPLE_W-1:0]        base;
    logic [ACC_W-1:0]           approx [LEVELS+1];
    logic signed [SAMPLE_W+1:0] diff;
    int                         diff_i;
    out_t                       q, d;

    pingpong_buffer #(.W(SAMPLE_W), .BLOCK(BLOCK)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_data (in_data),
        .s_vld   (s_vld),
        .s_dat   (s_dat),
        .overrun (overrun)
    );

    assign approx[0] = ACC_W'(s_dat);

    for (genvar j = 0; j < LEVELS; j++) begin : g_level
        haar_stage #(.W(ACC_W), .SPAN(1 << j)) u_lvl (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (s_vld),
            .x    (approx[j]),
            .y    (approx[j+1])
        );
    end

    sample_delay #(.W(SAMPLE_W), .DEPTH(DELAY)) u_align (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (s_vld),
        .din  (s_dat),
        .dout (dly_x)
    );

    assign base   = approx[LEVELS][ACC_W-1:LEVELS];
    assign diff   = $signed({2'b00, dly_x}) - $signed({2'b00, base});
    assign diff_i = int'(diff);

    always_comb begin
        d        = q;
        d.ovalid = 1'b0;
        if (s_vld) begin
            d.odata = OUT_W'(clamp_int(diff_i, SAT_LO, SAT_HI));
            if (q.cnt == CNT_W'(DELAY)) d.ovalid = 1'b1;
            else                        d.cnt    = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.ovalid;
    assign out_data  = q.odata;

    // R6: every output is produced from a sample streamed the cycle before
    a_r6_valid_follows_stream: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(s_vld));
endmodule

// File: tb/drift_canceller_tb.sv
module drift_canceller_tb;
    localparam int PERIOD = 10;
    localparam int SW     = 10;
    localparam int LV     = 3;
    localparam int BLK    = 16;
    localparam int OW     = 10;
    localparam int D      = (1 << (LV - 1)) - 1;
    localparam int WIN    = 1 << LV;
    localparam int HI     = (1 << (OW - 1)) - 1;
    localparam int LO     = -(1 << (OW - 1));
    localparam int NPAT   = 5;
    // pattern table: {kind, base, amplitude}
    // kind 0 constant, 1 ramp, 2 step up at mid-block, 3 alternate, 4 step down
    localparam int PAT [NPAT][3] = '{
        '{0, 500, 0},
        '{1, 100, 40},
        '{2, 0, 1023},
        '{3, 0, 1023},
        '{4, 1023, 0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_data = '0;
    logic          out_valid;
    logic [OW-1:0] out_data;
    logic          overrun;

    int checks = 0;
    int errors = 0;
    int proc [0:255];
    int nproc = 0;
    int got [0:255];
    int ngot = 0;
    int novr = 0;
    bit done = 1'b0;

    drift_canceller #(.SAMPLE_W(SW), .LEVELS(LV), .BLOCK(BLK), .OUT_W(OW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_data (out_data),
        .overrun  (overrun)
    );

    always #(PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && ngot < 256) begin
                got[ngot] = int'($signed(out_data));
                ngot++;
            end
            if (overrun) novr++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sample_of(input int kind, input int b, input int a, input int i);
        int v;
        case (kind)
            0: v = b;
            1: v = b + a * i;
            2: v = (i < BLK/2) ? b : a;
            3: v = (i % 2 == 0) ? b : a;
            default: v = (i < BLK/2) ? b : a;
        endcase
        if (v > 1023) v = 1023;
        if (v < 0) v = 0;
        return v;
    endfunction

    // reference: delayed sample minus floor of window mean, zeros before reset, clamped
    function automatic int model(input int n);
        int s = 0;
        int v;
        for (int i = n - WIN + 1; i <= n; i++) begin
            if (i >= 0) s += proc[i];
        end
        v = proc[n - D] - s / WIN;
        if (v > HI) v = HI;
        if (v < LO) v = LO;
        return v;
    endfunction

    task automatic push(input int v, input bit gap);
        in_valid = 1'b1;
        in_data  = SW'(v);
        @(negedge clk);
        if (gap) begin
            in_valid = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
        check(overrun == 1'b0, "R8 overrun in reset", int'(overrun), 0);
        nproc = 0;
        ngot = 0;
        novr = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic compare_stream(input string tag);
        check(ngot == nproc - D, {tag, " R6 output count"}, ngot, nproc - D);
        for (int k = 0; k < ngot && k < nproc - D; k++) begin
            int e = model(k + D);
            check(got[k] == e, {tag, " R2 R3 R4 R5 R9 sample"}, got[k], e);
        end
    endtask

    initial begin
        do_reset();

        // table-driven blocks at half rate: R1, R2, R3, R4, R5, R9
        for (int p = 0; p < NPAT; p++) begin
            for (int i = 0; i < BLK; i++) begin
                int v = sample_of(PAT[p][0], PAT[p][1], PAT[p][2], i);
                proc[nproc] = v;
                nproc++;
                push(v, 1'b1);
            end
        end
        repeat (3 * BLK) @(negedge clk);
        compare_stream("patterns");
        check(novr == 0, "R1 no overrun at half rate", novr, 0);

        // R8: second reset after non-zero history, R5 zeros again
        do_reset();
        for (int i = 0; i < BLK; i++) begin
            proc[nproc] = 900;
            nproc++;
            push(900, 1'b1);
        end
        repeat (3 * BLK) @(negedge clk);
        compare_stream("R8 after reset");
        check(ngot > 0 && got[0] == 900 - 900 / WIN * 0 - 0 - (900 * 4) / WIN + (900 * 4) / WIN - (900 * 4) / WIN,
              "R5 first output from zero history", ngot > 0 ? got[0] : -9999, 900 - (900 * 4) / WIN);

        // R7: two blocks back to back at full rate, then one slow block
        do_reset();
        for (int i = 0; i < BLK; i++) begin
            int v = 30 * i + 5;
            proc[nproc] = v;
            nproc++;
            push(v, 1'b0);
        end
        for (int i = 0; i < BLK; i++) begin
            push(1000 - 7 * i, 1'b0);
        end
        check(ngot < BLK, "R7 first block still streaming", ngot, BLK - 1);
        for (int i = 0; i < BLK; i++) begin
            int v = (i % 3) * 300;
            proc[nproc] = v;
            nproc++;
            push(v, 1'b1);
        end
        repeat (3 * BLK) @(negedge clk);
        check(novr == 1, "R7 overrun pulses", novr, 1);
        compare_stream("R7 dropped block");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule